// File: doc/BRIEF.md
# Fieldbus-Synchronized I/O Cycle Scheduler

This block decides when the local I/O bus engine begins a transfer cycle. It watches each cycle until the engine reports completion and measures how long the cycle took. Depending on the selected mode, it either runs cycles on its own or ties them to data-exchange telegrams from a fieldbus master. The block does not decode telegrams and does not move I/O data. It sees only a telegram-received pulse, a flag that says the telegram carried output bytes, and a done pulse from the engine. All pins are plain control and status signals, so there is no stream interface and no back-pressure.

There are two free-running modes. Slow free-run starts a cycle when a main-loop slot is granted. Fast free-run restarts by itself after a short gap whose length follows the last measured duration. There are three telegram-synchronous modes:
- Immediate start.
- Start after a programmed delay, which gives fresher inputs.
- A split schedule: an immediate cycle, the delay, then a second cycle.

The block keeps a cycle counter byte that never shows zero, so the master can tell whether exactly the expected number of cycles ran per telegram. It also keeps a sticky overrun flag for telegrams that arrive too early.

Top module: `iocyc_sched`

## Requirements
- R1: The mode comes from `cfg_mode`, with bit0 = fast select, bit1 = free-run select, bit2 = delayed-start select and bit3 = split select.
  - 4'b0010 is slow free-run.
  - 4'b0011 is fast free-run.
  - 4'b0000 is standard synchronous.
  - 4'b0100 is delayed synchronous.
  - 4'b1000 is two-cycle synchronous.
  - Any other code behaves as slow free-run.
- R2: In slow free-run, a `slot_grant` pulse seen while `busy` is low makes `cyc_start` pulse on the next clock. A grant seen while `busy` is high is ignored.
- R3: In fast free-run, a cycle starts on the clock after the block becomes idle. Each completion leaves the block busy for floor(duration/8) further `us_tick` pulses before it goes idle. With a gap of zero it goes idle at once.
- R4: A trigger is a `tlg_rx` pulse with `tlg_has_out` high.
  - In standard synchronous mode, a trigger seen while idle makes `cyc_start` pulse on the next clock.
  - A telegram with `tlg_has_out` low has no effect in any mode.
- R5: In delayed mode, a trigger loads the delay D = {`cfg_dly_hi`, `cfg_dly_lo`} (big-endian microseconds).
  - `cyc_start` pulses on the clock after the D-th `us_tick` that follows the trigger clock.
  - With D = 0, the cycle starts at once.
- R6: In two-cycle mode, a trigger starts the first cycle at once. After that cycle completes, the block waits D ticks (zero means no wait) and starts the second cycle. It goes idle after the second completion.
- R7: `cyc_dur` shows the number of `us_tick` pulses counted from the `cyc_start` clock through the accepted `cyc_done` clock. It updates on the clock after completion, saturates at all ones and changes at no other time.
- R8: `cyc_cnt` resets to 1 and advances by one on every accepted completion. 255 is followed by 1, so the counter never shows 0.
- R9: In a synchronous mode, a trigger seen while `busy` is high sets `overrun` and is otherwise ignored. `overrun` stays set until `ovr_clr` is seen, and a new set wins over a clear in the same clock.
- R10: After reset, `busy`, `cyc_start`, `overrun` and `cyc_dur` are 0 and `cyc_cnt` is 1. `cfg_mode` and the delay are sampled only on clocks where `busy` is low.
- R11: `cyc_done` while no cycle is running (idle, delay or gap) is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| us_tick | input | 1 | One-clock pulse per microsecond |
| tlg_rx | input | 1 | Data-exchange telegram received (pulse) |
| tlg_has_out | input | 1 | That telegram carried output bytes |
| slot_grant | input | 1 | Main-loop slot grant pulse (slow free-run) |
| cyc_done | input | 1 | I/O bus engine finished its cycle (pulse) |
| cfg_mode | input | 4 | Mode select bits, see R1 |
| cfg_dly_hi | input | 8 | Delay high byte, microseconds |
| cfg_dly_lo | input | 8 | Delay low byte, microseconds |
| ovr_clr | input | 1 | Clears the overrun flag |
| cyc_start | output | 1 | One-clock pulse: start an I/O bus cycle |
| busy | output | 1 | Cycle, delay or gap in progress |
| cyc_dur | output | 16 | Last measured cycle duration, microseconds |
| cyc_cnt | output | 8 | Completed-cycle counter, skips zero |
| overrun | output | 1 | Sticky: trigger arrived while busy |

## Verification
A stuck or wrong phase state shows up as a missing, early or repeated `cyc_start`, or as a `busy` level that differs from the model on the very next clock. The reference model checks both outputs every cycle, so the error is seen within one clock of its cause. A bad delay or gap counter moves the start pulse or the idle edge by whole tick periods. Miscounting in the duration or cycle counter shows on `cyc_dur` or `cyc_cnt` on the clock after the completion it affects.

// File: rtl/iocyc_pkg.sv
package iocyc_pkg;

  typedef enum logic [2:0] {
    M_SLOW = 3'd0,
    M_FAST = 3'd1,
    M_SYNC = 3'd2,
    M_DLY1 = 3'd3,
    M_TWO  = 3'd4
  } sched_mode_e;

  typedef enum logic [1:0] {
    S_IDLE,
    S_RUN,
    S_WAIT,
    S_GAP
  } sched_st_e;

  function automatic logic is_sync(sched_mode_e m);
    return (m == M_SYNC) || (m == M_DLY1) || (m == M_TWO);
  endfunction

endpackage

// File: rtl/iocyc_mode_dec.sv
module iocyc_mode_dec
  import iocyc_pkg::*;
(
  input  logic [3:0]  sel,
  output sched_mode_e mode
);
  // sel = {split, delayed, free-run, fast}
  always_comb begin
    case (sel)
      4'b0010: mode = M_SLOW;
      4'b0011: mode = M_FAST;
      4'b0000: mode = M_SYNC;
      4'b0100: mode = M_DLY1;
      4'b1000: mode = M_TWO;
      default: mode = M_SLOW;
    endcase
  end
endmodule

// File: rtl/iocyc_dur_meter.sv
module iocyc_dur_meter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         run,
  input  logic         tick,
  input  logic         capture,
  output logic [W-1:0] dur_live,
  output logic [W-1:0] dur_q
);
  logic [W-1:0] acc_q;

  // running count including this clock's tick, held at all ones
  always_comb begin
    if (tick && (acc_q != '1)) dur_live = acc_q + W'(1);
    else                       dur_live = acc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      dur_q <= '0;
    end else begin
      if (clr)      acc_q <= '0;
      else if (run) acc_q <= dur_live;
      if (capture)  dur_q <= dur_live;
    end
  end
endmodule

// File: rtl/iocyc_wrap_cnt.sv
module iocyc_wrap_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  output logic [W-1:0] val
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       val <= W'(1);
    else if (step) begin
      if (val == '1)  val <= W'(1);
      else            val <= val + W'(1);
    end
  end
endmodule

// File: rtl/iocyc_tick_down.sv
module iocyc_tick_down #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         tick,
  output logic         expire
);
  logic [W-1:0] cnt_q;

  assign expire = tick && (cnt_q == W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     cnt_q <= '0;
    else if (load)                  cnt_q <= load_val;
    else if (tick && cnt_q != '0)   cnt_q <= cnt_q - W'(1);
  end
endmodule

// File: rtl/iocyc_sched.sv
module iocyc_sched
  import iocyc_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int DUR_W     = 16,
  parameter int GAP_SHIFT = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             us_tick,
  input  logic             tlg_rx,
  input  logic             tlg_has_out,
  input  logic             slot_grant,
  input  logic             cyc_done,
  input  logic [3:0]       cfg_mode,
  input  logic [7:0]       cfg_dly_hi,
  input  logic [7:0]       cfg_dly_lo,
  input  logic             ovr_clr,
  output logic             cyc_start,
  output logic             busy,
  output logic [DUR_W-1:0] cyc_dur,
  output logic [CNT_W-1:0] cyc_cnt,
  output logic             overrun
);
  localparam int DLY_W = 16;
  localparam int WC_W  = (DLY_W > DUR_W) ? DLY_W : DUR_W;

  sched_st_e   st_q, st_d;
  sched_mode_e mode_cfg, mode_q, mode_use;
  logic [DLY_W-1:0] cfg_delay, dly_q;
  logic             first_q, first_d;
  logic             start_d, start_q;
  logic             ovr_q;
  logic             trig, done_ok, expire, wload;
  logic [WC_W-1:0]  wval;
  logic [DUR_W-1:0] dur_live, gap_val;

  assign cfg_delay = {cfg_dly_hi, cfg_dly_lo};
  assign trig      = tlg_rx & tlg_has_out;
  assign done_ok   = cyc_done && (st_q == S_RUN);
  assign mode_use  = (st_q == S_IDLE) ? mode_cfg : mode_q;
  assign gap_val   = dur_live >> GAP_SHIFT;

  iocyc_mode_dec u_dec (
    .sel  (cfg_mode),
    .mode (mode_cfg)
  );

  always_comb begin
    st_d    = st_q;
    start_d = 1'b0;
    first_d = first_q;
    wload   = 1'b0;
    wval    = '0;
    case (st_q)
      S_IDLE: begin
        case (mode_use)
          M_SLOW: start_d = slot_grant;
          M_FAST: start_d = 1'b1;
          M_SYNC: start_d = trig;
          M_DLY1: begin
            if (trig) begin
              if (cfg_delay == '0) start_d = 1'b1;
              else begin
                st_d  = S_WAIT;
                wload = 1'b1;
                wval  = WC_W'(cfg_delay);
              end
            end
          end
          M_TWO: begin
            if (trig) begin
              start_d = 1'b1;
              first_d = 1'b1;
            end
          end
          default: start_d = 1'b0;
        endcase
      end
      S_RUN: begin
        if (done_ok) begin
          if (mode_q == M_FAST) begin
            if (gap_val == '0) st_d = S_IDLE;
            else begin
              st_d  = S_GAP;
              wload = 1'b1;
              wval  = WC_W'(gap_val);
            end
          end else if (mode_q == M_TWO && first_q) begin
            first_d = 1'b0;
            if (dly_q == '0) start_d = 1'b1;
            else begin
              st_d  = S_WAIT;
              wload = 1'b1;
              wval  = WC_W'(dly_q);
            end
          end else begin
            st_d = S_IDLE;
          end
        end
      end
      S_WAIT:  if (expire) start_d = 1'b1;
      S_GAP:   if (expire) st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
    if (start_d) st_d = S_RUN;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      start_q <= 1'b0;
      first_q <= 1'b0;
      mode_q  <= M_SLOW;
      dly_q   <= '0;
      ovr_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      start_q <= start_d;
      first_q <= first_d;
      if (st_q == S_IDLE) begin
        mode_q <= mode_cfg;
        dly_q  <= cfg_delay;
      end
      if (st_q != S_IDLE && trig && is_sync(mode_q)) ovr_q <= 1'b1;
      else if (ovr_clr)                               ovr_q <= 1'b0;
    end
  end

  iocyc_tick_down #(.W(WC_W)) u_wait (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (wload),
    .load_val (wval),
    .tick     (us_tick),
    .expire   (expire)
  );

  iocyc_dur_meter #(.W(DUR_W)) u_dur (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (start_d),
    .run      (st_q == S_RUN),
    .tick     (us_tick),
    .capture  (done_ok),
    .dur_live (dur_live),
    .dur_q    (cyc_dur)
  );

  iocyc_wrap_cnt #(.W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (done_ok),
    .val   (cyc_cnt)
  );

  assign cyc_start = start_q;
  assign busy      = (st_q != S_IDLE);
  assign overrun   = ovr_q;

endmodule

// File: rtl/iocyc_sched_chk.sv
module iocyc_sched_chk #(
  parameter int CNT_W = 8,
  parameter int DUR_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tlg_rx,
  input logic             tlg_has_out,
  input logic             cyc_done,
  input logic             ovr_clr,
  input logic             cyc_start,
  input logic             busy,
  input logic [DUR_W-1:0] cyc_dur,
  input logic [CNT_W-1:0] cyc_cnt,
  input logic             overrun
);
  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  a_r8_never_zero: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_cnt != '0);

  a_r8_step_wraps: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && cyc_cnt != $past(cyc_cnt)) |->
      cyc_cnt == (($past(cyc_cnt) == '1) ? CNT_W'(1) : $past(cyc_cnt) + CNT_W'(1)));

  a_r11_cnt_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && cyc_cnt != $past(cyc_cnt)) |-> $past(cyc_done && busy));

  a_r7_dur_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && cyc_dur != $past(cyc_dur)) |-> $past(cyc_done && busy));

  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !ovr_clr) |=> overrun);

  a_r9_set_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $rose(overrun)) |-> $past(tlg_rx && tlg_has_out && busy));

  a_r2_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_start |-> busy);

endmodule

bind iocyc_sched iocyc_sched_chk #(.CNT_W(CNT_W), .DUR_W(DUR_W)) u_chk (.*);

// File: tb/sim_iocyc_sched.sv
module sim_iocyc_sched;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n, us_tick, tlg_rx, tlg_has_out, slot_grant, cyc_done, ovr_clr;
  logic [3:0] cfg_mode;
  logic [7:0] cfg_dly_hi, cfg_dly_lo;
  logic       cyc_start, busy, overrun;
  logic [15:0] cyc_dur;
  logic [7:0]  cyc_cnt;
  logic        eng_done, stray_done;

  assign cyc_done = eng_done | stray_done;

  iocyc_sched u0 (.*);

  int checks = 0, fails = 0, cycles = 0;
  string cur_req = "R10";
  bit cmp_en = 0, wrap_seen = 0, done_flag = 0;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done_flag) begin
      done_flag = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  // microsecond tick: one clock in three
  int tdiv = 0;
  always @(negedge clk) begin
    tdiv = (tdiv == 2) ? 0 : tdiv + 1;
    us_tick = (tdiv == 0);
  end

  // engine stand-in
  int eng_len = 6, eng_cnt = 0;
  always @(negedge clk) begin
    eng_done = 1'b0;
    if (eng_cnt > 0) begin
      eng_cnt--;
      if (eng_cnt == 0) eng_done = 1'b1;
    end
    if (cyc_start) eng_cnt = eng_len;
  end

  // behavioural reference: 0 idle, 1 running, 2 delay, 3 gap
  int ms, mmode, mdly, mfirst, mw, mrun, mdur, mcnt, movr, mstart, go, trig;

  function automatic int dec(logic [3:0] s);
    case (s)
      4'b0010: return 0;
      4'b0011: return 1;
      4'b0000: return 2;
      4'b0100: return 3;
      4'b1000: return 4;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      ms = 0; mmode = 0; mdly = 0; mfirst = 0; mw = 0; mrun = 0;
      mdur = 0; mcnt = 1; movr = 0; mstart = 0;
    end else begin
      trig = int'(tlg_rx && tlg_has_out);
      go = 0;
      if (ms != 0 && trig != 0 && mmode >= 2) movr = 1;
      else if (ovr_clr) movr = 0;
      case (ms)
        0: begin
          mmode = dec(cfg_mode);
          mdly  = {cfg_dly_hi, cfg_dly_lo};
          if (mmode == 0)      go = int'(slot_grant);
          else if (mmode == 1) go = 1;
          else if (mmode == 2) go = trig;
          else if (mmode == 3) begin
            if (trig != 0) begin
              if (mdly == 0) go = 1;
              else begin ms = 2; mw = mdly; end
            end
          end else if (trig != 0) begin
            go = 1; mfirst = 1;
          end
        end
        1: begin
          if (us_tick && mrun < 65535) mrun++;
          if (cyc_done) begin
            mdur = mrun;
            mcnt = (mcnt == 255) ? 1 : mcnt + 1;
            if (mmode == 1) begin
              if (mrun / 8 == 0) ms = 0;
              else begin ms = 3; mw = mrun / 8; end
            end else if (mmode == 4 && mfirst != 0) begin
              mfirst = 0;
              if (mdly == 0) go = 1;
              else begin ms = 2; mw = mdly; end
            end else ms = 0;
          end
        end
        2: if (us_tick) begin
          if (mw == 1) go = 1; else mw--;
        end
        default: if (us_tick) begin
          if (mw == 1) ms = 0; else mw--;
        end
      endcase
      if (go != 0) begin ms = 1; mrun = 0; end
      mstart = go;
    end
  end

  int prev_cnt = 1;
  always @(negedge clk) begin
    if (rst_n && cmp_en) begin
      chk({cur_req, " R2 cyc_start"}, int'(cyc_start), mstart);
      chk({cur_req, " R10 busy"}, int'(busy), int'(ms != 0));
      chk({cur_req, " R7 cyc_dur"}, int'(cyc_dur), mdur);
      chk({cur_req, " R8 cyc_cnt"}, int'(cyc_cnt), mcnt);
      chk({cur_req, " R9 overrun"}, int'(overrun), movr);
      if (prev_cnt == 255 && cyc_cnt == 8'd1) wrap_seen = 1;
      prev_cnt = int'(cyc_cnt);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: got %0d expected below %0d", cycles, 150000);
      finish_up();
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_tlg(bit has);
    tlg_rx = 1'b1; tlg_has_out = has;
    @(negedge clk);
    tlg_rx = 1'b0; tlg_has_out = 1'b0;
  endtask

  task automatic pulse_grant();
    slot_grant = 1'b1;
    @(negedge clk);
    slot_grant = 1'b0;
  endtask

  task automatic wait_idle(int lim);
    for (int i = 0; i < lim && busy; i++) @(negedge clk);
  endtask

  initial begin
    rst_n = 0; tlg_rx = 0; tlg_has_out = 0; slot_grant = 0; stray_done = 0;
    ovr_clr = 0; cfg_mode = 4'b0010; cfg_dly_hi = 0; cfg_dly_lo = 0;
    step(3);
    rst_n = 1;
    step(1);
    cmp_en = 1;
    cur_req = "R10";
    chk("R10 reset cnt", int'(cyc_cnt), 1);
    chk("R10 reset busy", int'(busy), 0);
    chk("R10 reset start", int'(cyc_start), 0);
    chk("R10 reset overrun", int'(overrun), 0);
    chk("R10 reset dur", int'(cyc_dur), 0);

    // unlisted code acts as slow free-run
    cur_req = "R1";
    cfg_mode = 4'b1111;
    step(12);
    chk("R1 unlisted code idle without grant", int'(busy), 0);
    pulse_grant();
    chk("R1 unlisted code starts on grant", int'(cyc_start), 1);
    wait_idle(100);
    chk("R1 cnt after first cycle", int'(cyc_cnt), 2);

    cur_req = "R2";
    cfg_mode = 4'b0010;
    step(2);
    pulse_grant();
    chk("R2 start on grant", int'(cyc_start), 1);
    pulse_grant();
    wait_idle(100);
    step(3);
    chk("R2 grant while busy ignored", int'(cyc_cnt), 3);

    cur_req = "R4";
    cfg_mode = 4'b0000;
    step(2);
    pulse_tlg(1'b0);
    chk("R4 telegram without outputs ignored", int'(busy), 0);
    pulse_tlg(1'b1);
    chk("R4 immediate start", int'(cyc_start), 1);
    wait_idle(100);
    chk("R4 cnt", int'(cyc_cnt), 4);

    cur_req = "R11";
    stray_done = 1'b1; step(1); stray_done = 1'b0; step(2);
    chk("R11 stray done ignored", int'(cyc_cnt), 4);

    cur_req = "R9";
    eng_len = 40;
    pulse_tlg(1'b1);
    step(3);
    pulse_tlg(1'b1);
    chk("R9 overrun set", int'(overrun), 1);
    wait_idle(200);
    chk("R9 early telegram ignored", int'(cyc_cnt), 5);
    chk("R9 overrun sticky", int'(overrun), 1);
    ovr_clr = 1'b1; step(1); ovr_clr = 1'b0;
    chk("R9 overrun cleared", int'(overrun), 0);

    cur_req = "R7";
    eng_len = 30;
    pulse_tlg(1'b1);
    wait_idle(200);
    step(1);
    chk("R7 duration in range", int'(cyc_dur >= 16'd10 && cyc_dur <= 16'd11), 1);

    cur_req = "R5";
    eng_len = 5;
    cfg_mode = 4'b0100; cfg_dly_hi = 8'h00; cfg_dly_lo = 8'h07;
    step(2);
    pulse_tlg(1'b1);
    chk("R5 no start during delay", int'(cyc_start), 0);
    chk("R5 busy during delay", int'(busy), 1);
    wait_idle(400);
    chk("R5 cnt", int'(cyc_cnt), 7);
    cfg_dly_hi = 8'h01; cfg_dly_lo = 8'h02;
    step(1);
    pulse_tlg(1'b1);
    step(600);
    chk("R5 big-endian delay still pending", int'(busy), 1);
    wait_idle(2000);
    cfg_dly_hi = 8'h00; cfg_dly_lo = 8'h00;
    step(1);
    pulse_tlg(1'b1);
    chk("R5 zero delay immediate", int'(cyc_start), 1);
    wait_idle(100);
    chk("R5 cnt after zero delay", int'(cyc_cnt), 9);

    cur_req = "R6";
    cfg_mode = 4'b1000; cfg_dly_lo = 8'h04;
    step(2);
    pulse_tlg(1'b1);
    chk("R6 first cycle immediate", int'(cyc_start), 1);
    wait_idle(400);
    chk("R6 two cycles", int'(cyc_cnt), 11);
    cfg_dly_lo = 8'h00;
    step(1);
    pulse_tlg(1'b1);
    wait_idle(400);
    chk("R6 two cycles zero delay", int'(cyc_cnt), 13);

    cur_req = "R3";
    eng_len = 25;
    cfg_mode = 4'b0011;
    step(200);
    eng_len = 2;
    cur_req = "R8";
    for (int i = 0; i < 6000 && !wrap_seen; i++) @(negedge clk);
    chk("R8 counter wrapped 255 to 1", int'(wrap_seen), 1);
    cur_req = "R10";
    cfg_mode = 4'b0000;
    wait_idle(400);
    step(10);
    chk("R10 new mode taken when idle", int'(busy), 0);
    finish_up();
  end
endmodule